// File: doc/BRIEF.md
# Frame Preamble Search Engine

This block sits behind a symbol slicer in a data radio receiver. It takes one 2-bit symbol each time the symbol strobe is high. Once the host pulses `start`, the engine looks for a fixed 24-symbol synchronization word. The comparison window slides by one symbol on every strobe. When the word is found, the next symbol is taken as a channel status symbol and reported to the host. After that, 22 symbols carrying a station identifier and its checksum are shifted in.

A checksum mismatch throws the identifier away. The engine then goes back to hunting, and it needs a complete new synchronization word before it can lock again. When the checksum matches, one more status symbol is captured. At that point the three identifier bytes are published and the search ends. The host then sees status-ready, buffer-free and the interrupt all set in the same cycle.

Status-ready, buffer-free and the interrupt stay set until the host pulses `ack`. The interrupt for the first status symbol can be masked.

Top module: `preamble_hunter`

## Requirements
- R1: After reset, `stat_rdy`, `buf_free`, `irq`, `crc_err` and `busy` are 0, and `stat_val` and `id_bytes` are 0.
- R2: A `start` pulse arms the search. From the next cycle `busy` and `crc_err` are 1, and any progress already made is discarded, including a partly received identifier. A symbol strobed in the same cycle as `start` is not taken.
- R3: A lock needs 24 consecutive symbols, all strobed since the search was armed, that equal `SYNC_WORD`. The first symbol received is compared with bits [47:46]. The window slides, so a near miss does not prevent a later match.
- R4: The symbol after a lock is written to `stat_val`, and `stat_rdy` goes to 1 in the cycle after its strobe. `irq` is set at the same time only when `stat_irq_en` is 1.
- R5: The 22 symbols after that status symbol form a 44-bit word, most significant bit first. Within a symbol, `sym_in[1]` is the earlier bit. The word holds the 24 identifier bits followed by a 20-bit checksum. The checksum is a non-reflected CRC with polynomial `CRC_POLY` and an initial value of 0, fed most significant bit first.
- R6: On a checksum mismatch the engine goes back to hunting and stays busy. `buf_free` is not raised and `id_bytes` keeps its old value. A symbol that directly follows the rejected word is not treated as a status symbol.
- R7: On a checksum match, the strobe of the following symbol makes all of these true one cycle later: `stat_val` holds that symbol; `stat_rdy`, `buf_free` and `irq` are 1 whatever `stat_irq_en` is; `crc_err` is 0; `id_bytes` holds the identifier; `busy` is 0.
- R8: `ack` clears `stat_rdy`, `buf_free` and `irq`, and leaves `stat_val`, `crc_err` and `id_bytes` unchanged. If a status symbol is taken in the same cycle as `ack`, the flags it sets end up at 1.
- R9: While not busy, symbol strobes change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sym_stb | input | 1 | Symbol strobe, one cycle per received symbol |
| sym_in | input | 2 | Received symbol |
| start | input | 1 | Arm (or re-arm) the search |
| ack | input | 1 | Host acknowledge, clears the sticky flags |
| stat_irq_en | input | 1 | Enable the interrupt on the first status symbol |
| stat_val | output | 2 | Last captured status symbol |
| stat_rdy | output | 1 | A status symbol has been captured |
| buf_free | output | 1 | Identifier bytes are available |
| crc_err | output | 1 | No valid identifier since the last arm |
| irq | output | 1 | Interrupt request |
| id_bytes | output | 24 | Station identifier, three bytes |
| busy | output | 1 | Search in progress |

## Verification
Two things can land in the same cycle: the host acknowledge and the capture of a status symbol. The bench provokes this by raising `ack` in the same cycle as the strobe of the first status symbol, with the interrupt enabled. It then expects `stat_rdy` and `irq` to be 1 afterwards, because setting a flag wins over clearing it. A second collision is `start` together with a symbol strobe. This is judged by sending only 23 further symbols of the synchronization word and checking that no lock follows.

// File: rtl/psr_pkg.sv
package psr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_HUNT,
    ST_LEAD,
    ST_IDENT,
    ST_TAIL
  } hunt_state_t;

endpackage

// File: rtl/psr_sync_match.sv
module psr_sync_match #(
  parameter int SYM_W     = 2,
  parameter int SYNC_SYMS = 24,
  parameter logic [SYM_W*SYNC_SYMS-1:0] PATTERN = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             shift_en,
  input  logic [SYM_W-1:0] sym,
  output logic             hit
);
  localparam int PAT_W = SYM_W * SYNC_SYMS;
  localparam int CNT_W = $clog2(SYNC_SYMS + 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(SYNC_SYMS);
  localparam logic [CNT_W-1:0] NEAR = CNT_W'(SYNC_SYMS - 1);

  logic [PAT_W-1:0] win_q, win_d, win_nx;
  logic [CNT_W-1:0] fill_q, fill_d;

  assign win_nx = {win_q[PAT_W-SYM_W-1:0], sym};
  assign hit    = shift_en && !clr && (fill_q >= NEAR) && (win_nx == PATTERN);

  always_comb begin
    win_d  = win_q;
    fill_d = fill_q;
    if (clr) begin
      win_d  = '0;
      fill_d = '0;
    end else if (shift_en) begin
      win_d = win_nx;
      if (fill_q != FULL) fill_d = fill_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr || shift_en) begin
      win_q  <= win_d;
      fill_q <= fill_d;
    end
  end
endmodule

// File: rtl/psr_id_collect.sv
module psr_id_collect #(
  parameter int SYM_W   = 2,
  parameter int ID_SYMS = 22,
  parameter int ID_BITS = 24,
  parameter int CRC_W   = 20,
  parameter logic [CRC_W-1:0] CRC_POLY = '1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               shift_en,
  input  logic [SYM_W-1:0]   sym,
  output logic               last,
  output logic               crc_ok,
  output logic [ID_BITS-1:0] id_word
);
  localparam int WORD_W = SYM_W * ID_SYMS;
  localparam int CNT_W  = $clog2(ID_SYMS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(ID_SYMS - 1);

  logic [WORD_W-1:0] word_q, word_d, word_nx;
  logic [CNT_W-1:0]  cnt_q, cnt_d;

  function automatic logic [CRC_W-1:0] crc_of(input logic [ID_BITS-1:0] d);
    logic [CRC_W-1:0] c;
    logic             fb;
    c = '0;
    for (int i = ID_BITS - 1; i >= 0; i--) begin
      fb = c[CRC_W-1] ^ d[i];
      c  = {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
    end
    return c;
  endfunction

  assign word_nx = {word_q[WORD_W-SYM_W-1:0], sym};
  assign last    = shift_en && !clr && (cnt_q == LAST_IDX);
  assign crc_ok  = (crc_of(word_nx[WORD_W-1 -: ID_BITS]) == word_nx[CRC_W-1:0]);
  assign id_word = word_q[WORD_W-1 -: ID_BITS];

  always_comb begin
    word_d = word_q;
    cnt_d  = cnt_q;
    if (clr) begin
      cnt_d = '0;
    end else if (shift_en) begin
      word_d = word_nx;
      cnt_d  = (cnt_q == LAST_IDX) ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      cnt_q  <= '0;
    end else if (clr || shift_en) begin
      word_q <= word_d;
      cnt_q  <= cnt_d;
    end
  end
endmodule

// File: rtl/psr_status_regs.sv
module psr_status_regs #(
  parameter int SYM_W   = 2,
  parameter int ID_BITS = 24
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               arm,
  input  logic               stat_evt,
  input  logic               done_evt,
  input  logic [SYM_W-1:0]   sym,
  input  logic               irq_en,
  input  logic               ack,
  input  logic [ID_BITS-1:0] id_in,
  output logic [SYM_W-1:0]   stat_val,
  output logic               stat_rdy,
  output logic               buf_free,
  output logic               crc_err,
  output logic               irq,
  output logic [ID_BITS-1:0] id_bytes
);
  logic [SYM_W-1:0]   val_q, val_d;
  logic               rdy_q, rdy_d, free_q, free_d, err_q, err_d, irq_q, irq_d;
  logic [ID_BITS-1:0] id_q, id_d;
  logic               upd;

  always_comb begin
    val_d  = val_q;
    rdy_d  = rdy_q;
    free_d = free_q;
    err_d  = err_q;
    irq_d  = irq_q;
    id_d   = id_q;
    if (ack) begin
      rdy_d  = 1'b0;
      free_d = 1'b0;
      irq_d  = 1'b0;
    end
    if (arm) err_d = 1'b1;
    if (stat_evt) begin
      val_d = sym;
      rdy_d = 1'b1;
      if (irq_en || done_evt) irq_d = 1'b1;
    end
    if (done_evt) begin
      free_d = 1'b1;
      err_d  = 1'b0;
      id_d   = id_in;
    end
  end

  assign upd = ack || arm || stat_evt || done_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      val_q  <= '0;
      rdy_q  <= 1'b0;
      free_q <= 1'b0;
      err_q  <= 1'b0;
      irq_q  <= 1'b0;
      id_q   <= '0;
    end else if (upd) begin
      val_q  <= val_d;
      rdy_q  <= rdy_d;
      free_q <= free_d;
      err_q  <= err_d;
      irq_q  <= irq_d;
      id_q   <= id_d;
    end
  end

  assign stat_val = val_q;
  assign stat_rdy = rdy_q;
  assign buf_free = free_q;
  assign crc_err  = err_q;
  assign irq      = irq_q;
  assign id_bytes = id_q;
endmodule

// File: rtl/preamble_hunter.sv
module preamble_hunter #(
  parameter int SYM_W     = 2,
  parameter int SYNC_SYMS = 24,
  parameter int ID_SYMS   = 22,
  parameter int ID_BITS   = 24,
  parameter int CRC_W     = 20,
  parameter logic [SYM_W*SYNC_SYMS-1:0] SYNC_WORD = 48'h5A3C_F096_E1B7,
  parameter logic [CRC_W-1:0]           CRC_POLY  = 20'h41C5B
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               sym_stb,
  input  logic [SYM_W-1:0]   sym_in,
  input  logic               start,
  input  logic               ack,
  input  logic               stat_irq_en,
  output logic [SYM_W-1:0]   stat_val,
  output logic               stat_rdy,
  output logic               buf_free,
  output logic               crc_err,
  output logic               irq,
  output logic [ID_BITS-1:0] id_bytes,
  output logic               busy
);
  import psr_pkg::*;

  hunt_state_t        state_q, state_d;
  logic               stb_eff, sync_hit, id_last, id_ok, id_fail;
  logic               sync_clr, stat_evt, done_evt;
  logic [ID_BITS-1:0] id_word;

  assign stb_eff  = sym_stb && !start;
  assign id_fail  = id_last && !id_ok;
  assign sync_clr = start || id_fail;
  assign stat_evt = stb_eff && (state_q == ST_LEAD || state_q == ST_TAIL);
  assign done_evt = stb_eff && (state_q == ST_TAIL);
  assign busy     = (state_q != ST_IDLE);

  psr_sync_match #(
    .SYM_W(SYM_W), .SYNC_SYMS(SYNC_SYMS), .PATTERN(SYNC_WORD)
  ) u_sync (
    .clk(clk), .rst_n(rst_n), .clr(sync_clr),
    .shift_en(stb_eff && state_q == ST_HUNT),
    .sym(sym_in), .hit(sync_hit)
  );

  psr_id_collect #(
    .SYM_W(SYM_W), .ID_SYMS(ID_SYMS), .ID_BITS(ID_BITS),
    .CRC_W(CRC_W), .CRC_POLY(CRC_POLY)
  ) u_id (
    .clk(clk), .rst_n(rst_n), .clr(start),
    .shift_en(stb_eff && state_q == ST_IDENT),
    .sym(sym_in), .last(id_last), .crc_ok(id_ok), .id_word(id_word)
  );

  psr_status_regs #(.SYM_W(SYM_W), .ID_BITS(ID_BITS)) u_stat (
    .clk(clk), .rst_n(rst_n), .arm(start), .stat_evt(stat_evt),
    .done_evt(done_evt), .sym(sym_in), .irq_en(stat_irq_en), .ack(ack),
    .id_in(id_word), .stat_val(stat_val), .stat_rdy(stat_rdy),
    .buf_free(buf_free), .crc_err(crc_err), .irq(irq), .id_bytes(id_bytes)
  );

  always_comb begin
    state_d = state_q;
    if (start) begin
      state_d = ST_HUNT;
    end else if (stb_eff) begin
      case (state_q)
        ST_HUNT:  if (sync_hit) state_d = ST_LEAD;
        ST_LEAD:  state_d = ST_IDENT;
        ST_IDENT: if (id_last) state_d = id_ok ? ST_TAIL : ST_HUNT;
        ST_TAIL:  state_d = ST_IDLE;
        default:  state_d = state_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  state_q <= ST_IDLE;
    else if (start || stb_eff)   state_q <= state_d;
  end
endmodule

// File: rtl/psr_checker.sv
module psr_checker #(
  parameter int SYM_W   = 2,
  parameter int ID_BITS = 24
) (
  input logic               clk,
  input logic               rst_n,
  input logic               start,
  input logic [SYM_W-1:0]   sym_in,
  input logic               ack,
  input logic               stat_irq_en,
  input logic [SYM_W-1:0]   stat_val,
  input logic               stat_rdy,
  input logic               buf_free,
  input logic               crc_err,
  input logic               irq,
  input logic [ID_BITS-1:0] id_bytes,
  input logic               busy,
  input logic               stat_evt,
  input logic               done_evt,
  input logic               id_fail
);
  AST_ARM_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> busy && crc_err); // R2
  AST_STAT_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
    stat_evt |=> stat_rdy && (stat_val == $past(sym_in))); // R4
  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq && !done_evt && !(stat_evt && stat_irq_en)) |=> !irq); // R4
  AST_BAD_CHECKSUM: assert property (@(posedge clk) disable iff (!rst_n)
    (id_fail && !buf_free && !start) |=> busy && !buf_free); // R6
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done_evt |=> stat_rdy && buf_free && irq && !crc_err && !busy); // R7
  AST_ID_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done_evt |=> $stable(id_bytes)); // R7
  AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (ack && !stat_evt) |=> !stat_rdy && !buf_free && !irq); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !start) |=> !busy && $stable(stat_val)); // R9
endmodule

bind preamble_hunter psr_checker #(.SYM_W(SYM_W), .ID_BITS(ID_BITS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .sym_in(sym_in), .ack(ack),
  .stat_irq_en(stat_irq_en), .stat_val(stat_val), .stat_rdy(stat_rdy),
  .buf_free(buf_free), .crc_err(crc_err), .irq(irq), .id_bytes(id_bytes),
  .busy(busy), .stat_evt(stat_evt), .done_evt(done_evt), .id_fail(id_fail)
);

// File: tb/sim_preamble_hunter.sv
`timescale 1ns/1ps
module sim_preamble_hunter;
  localparam logic [47:0] SYNC = 48'h5A3C_F096_E1B7;
  localparam logic [19:0] POLY = 20'h41C5B;
  // {irq_en, corrupt, s1, s2, id}
  localparam logic [29:0] VEC [0:5] = '{
    {1'b1, 1'b0, 2'd2, 2'd1, 24'hC0FFEE},
    {1'b0, 1'b0, 2'd3, 2'd0, 24'h000000},
    {1'b1, 1'b1, 2'd1, 2'd2, 24'h123456},
    {1'b0, 1'b0, 2'd0, 2'd3, 24'hFFFFFF},
    {1'b0, 1'b1, 2'd2, 2'd2, 24'hA5A5A5},
    {1'b1, 1'b0, 2'd1, 2'd1, 24'h5A0F3C}
  };

  logic clk = 1'b0, rst_n = 1'b0, sym_stb = 1'b0, start = 1'b0, ack = 1'b0, irq_en = 1'b0;
  logic [1:0]  sym_in = 2'd0;
  logic [1:0]  stat_val;
  logic        stat_rdy, buf_free, crc_err, irq, busy;
  logic [23:0] id_bytes;
  int checks = 0, failures = 0;
  logic [23:0] last_id = 24'h0;

  always #2 clk = ~clk;

  preamble_hunter u0 (
    .clk(clk), .rst_n(rst_n), .sym_stb(sym_stb), .sym_in(sym_in), .start(start),
    .ack(ack), .stat_irq_en(irq_en), .stat_val(stat_val), .stat_rdy(stat_rdy),
    .buf_free(buf_free), .crc_err(crc_err), .irq(irq), .id_bytes(id_bytes), .busy(busy)
  );

  function automatic logic [19:0] ref_crc(input logic [23:0] d);
    logic [19:0] r = '0;
    for (int i = 23; i >= 0; i--) begin
      if (r[19] ^ d[i]) r = {r[18:0], 1'b0} ^ POLY;
      else              r = {r[18:0], 1'b0};
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic send(input logic [1:0] s);
    @(negedge clk); sym_in = s; sym_stb = 1'b1;
    @(negedge clk); sym_stb = 1'b0;
  endtask

  task automatic pulse_start();
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic pulse_ack();
    @(negedge clk); ack = 1'b1;
    @(negedge clk); ack = 1'b0;
  endtask

  task automatic send_sync(input int first);
    for (int i = first; i < 24; i++) send(SYNC[47-2*i -: 2]);
  endtask

  task automatic send_id(input logic [23:0] id, input logic bad, input int from, input int upto);
    logic [43:0] w = {id, ref_crc(id) ^ {19'd0, bad}};
    for (int i = from; i < upto; i++) send(w[43-2*i -: 2]);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 flags", {stat_rdy, buf_free, irq, crc_err, busy}, 5'b0);
    chk("R1 stat_val/id", {stat_val, id_bytes}, 26'h0);

    // R9: strobes while idle do nothing
    send_sync(0); send(2'd3);
    chk("R9 idle", {stat_rdy, busy, stat_val}, 4'b0);

    // vector table
    for (int v = 0; v < 6; v++) begin
      logic [29:0] e = VEC[v];
      irq_en = e[29];
      pulse_start();
      chk("R2 armed", {busy, crc_err}, 2'b11);
      send(2'd3); send(2'd0); send(2'd3);
      send_sync(0);
      chk("R3 no early status", {stat_rdy}, 1'b0);
      send(e[27:26]);
      chk("R4 status", {stat_rdy, stat_val, irq}, {1'b1, e[27:26], e[29]});
      pulse_ack();
      chk("R8 ack clears", {stat_rdy, buf_free, irq}, 3'b0);
      send_id(e[23:0], e[28], 0, 22);
      if (e[28]) begin
        chk("R6 rejected", {buf_free, busy, id_bytes}, {2'b01, last_id});
        send(e[25:24]);
        chk("R6 no status", {stat_rdy}, 1'b0);
      end else begin
        send(e[25:24]);
        chk("R7 done", {stat_val, stat_rdy, buf_free, irq, crc_err, busy},
            {e[25:24], 5'b11100});
        chk("R5 id", id_bytes, e[23:0]);
        last_id = e[23:0];
        pulse_ack();
        chk("R8 ack keeps data", {stat_rdy, buf_free, irq, stat_val, crc_err, id_bytes},
            {3'b000, e[25:24], 1'b0, last_id});
      end
    end

    // R3: near miss then a real lock, irq masked
    irq_en = 1'b0;
    pulse_start();
    for (int i = 0; i < 23; i++) send(SYNC[47-2*i -: 2]);
    send(SYNC[1:0] ^ 2'd1);
    send(2'd2);
    chk("R3 near miss", {stat_rdy}, 1'b0);
    send_sync(0); send(2'd3);
    chk("R3 lock after miss", {stat_rdy, stat_val, irq}, 4'b1110);

    // R8: ack collides with status capture
    irq_en = 1'b1;
    pulse_ack();
    pulse_start();
    send_sync(0);
    @(negedge clk); sym_in = 2'd1; sym_stb = 1'b1; ack = 1'b1;
    @(negedge clk); sym_stb = 1'b0; ack = 1'b0;
    chk("R8 set wins", {stat_rdy, irq, stat_val}, 4'b1101);

    // R2: symbol with start is not taken
    pulse_ack();
    @(negedge clk); start = 1'b1; sym_stb = 1'b1; sym_in = SYNC[47:46];
    @(negedge clk); start = 1'b0; sym_stb = 1'b0;
    send_sync(1); send(2'd2);
    chk("R2 start strobe dropped", {stat_rdy}, 1'b0);

    // R2: restart mid-identifier discards progress
    pulse_start();
    send_sync(0); send(2'd1); pulse_ack();
    send_id(24'h0BEEF1, 1'b0, 0, 10);
    pulse_start();
    send_id(24'h0BEEF1, 1'b0, 10, 22); send(2'd2);
    chk("R2 restart", {buf_free, busy, crc_err, id_bytes}, {3'b011, last_id});

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule